// File: doc/BRIEF.md
# Serial Flash Command and Status Controller

This block is the device-side command front end of a serial NOR flash model. It watches an SPI mode-0 link (select, clock, data in) by oversampling it with the system clock. It assembles bytes while the select line is low and decodes the first byte of each frame as the opcode. It keeps the write-enable latch, a busy flag, an erase-suspend flag and a deep power-down flag. The storage array, multi-line data paths and analog timing are not modelled. A busy period is a countdown of system clock cycles whose length comes from a parameter.

Each opcode is screened when its first byte arrives, against the current mode: idle, busy, erase-suspended or powered down. A command that changes state takes effect only when select rises on a byte boundary with the expected byte count. Program, erase and status-write commands also need the write-enable latch to be set. Status reads, identification reads and a fast read return data on the serial output. The fast read returns a placeholder pattern that stands in for the array.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: Input bits are taken on rising clock edges, most significant bit first. Output bits change on falling edges, most significant bit first. The first bit of the first response byte is on the output after the falling edge that follows the last opcode bit. The output is low while select is high.
- R2: Opcode 05h returns the status byte: bit 0 busy, bit 1 write-enable latch, bit 7 erase suspended, the other bits 0. The status byte repeats for as long as clocks continue. Each repeated byte shows the live state, so busy can be seen falling within one frame.
- R3: Opcode 06h sets the latch and opcode 04h clears it. Each takes effect only in a frame of exactly one whole byte. A frame that ends part-way through a byte has no effect.
- R4: The following start a busy period only when the latch is 1 and select rises on a byte boundary: status write 01h with at least 2 bytes, page program 02h with at least 5 bytes, sector erase 20h or block erase D8h with exactly 4 bytes, and chip erase C7h with exactly 1 byte. Any other case is ignored.
- R5: A busy period lasts PROG_CYCLES clock cycles for 01h and 02h, and ERASE_CYCLES clock cycles for erases. The latch stays 1 while busy and clears when the period completes.
- R6: While busy, only 05h and 75h are accepted. A fast read gives no output (all zero), 04h has no effect, and the operation in progress continues.
- R7: Opcode 75h, sent while an erase is busy, suspends it. Busy reads 0, the suspend bit reads 1 and the remaining count is frozen. Sent during a program, 75h is ignored. While suspended, erase, program, status write and power-down are rejected.
- R8: Opcode 7Ah is ignored unless an erase is suspended. When one is, 7Ah clears the suspend bit and busy stays 1 until the remaining count runs out.
- R9: Opcode B9h (1 byte, not busy) enters power-down. In power-down every opcode except ABh is ignored, including 05h, and the output stays low. ABh leaves power-down. B9h sent while busy is ignored.
- R10: Fast read 0Bh is followed by a 3-byte address (most significant byte first) and one dummy byte. The data bytes that follow are the address low byte plus k for the k-th data byte, counting from 0.
- R11: Opcode 9Fh returns the 3 bytes of JEDEC_ID, most significant first. Opcode 4Bh returns the 8 bytes of UNIQUE_ID after 4 dummy bytes, most significant first.
- R12: After reset the latch, busy, suspend and power-down flags are 0, and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, synchronous to clk, mode 0 |
| cs_n | input | 1 | Active-low select, frames a command |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device |

## Verification
The hardest state to reach is a suspended erase whose countdown must be shown frozen and then completed after resume. The stimulus starts an erase, reads busy and suspends it. It then idles longer than a full erase and confirms the suspend bit is still set with busy clear. It resumes, confirms busy returns, and finally confirms completion and the cleared latch. The busy window is kept long enough that fast reads, latch changes and stray suspend/resume frames can all be sent inside one program period. The end of that period is watched byte by byte within a single continuous status frame.

// File: rtl/sfc_pkg.sv
// Shared opcode values and job kinds for the serial flash command controller.
// Assumes 8-bit opcodes delivered most significant bit first.
package sfc_pkg;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_SE    = 8'h20;
    localparam logic [7:0] OP_UID   = 8'h4B;
    localparam logic [7:0] OP_SUSP  = 8'h75;
    localparam logic [7:0] OP_RESM  = 8'h7A;
    localparam logic [7:0] OP_JID   = 8'h9F;
    localparam logic [7:0] OP_REL   = 8'hAB;
    localparam logic [7:0] OP_PDN   = 8'hB9;
    localparam logic [7:0] OP_CE    = 8'hC7;
    localparam logic [7:0] OP_BE    = 8'hD8;

    typedef enum logic {JOB_WRITE, JOB_ERASE} job_e;
endpackage

// File: rtl/sfc_spi_port.sv
// Mode-0 serial port sampled by the system clock.
// Assumes sclk, cs_n and mosi are already synchronous to clk and that
// each sclk phase lasts several clk cycles. Reports each whole byte,
// and on select rising reports whether the frame ended on a byte boundary.
module sfc_spi_port #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    input  logic [7:0]       resp_byte,
    output logic             miso,
    output logic             byte_stb,
    output logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             end_stb,
    output logic             end_whole,
    output logic [CNT_W-1:0] end_bytes
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic       sclk_q, cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr, tx_sr;
    logic       rise, fall, cs_up;

    assign rise  = !cs_n && sclk && !sclk_q;
    assign fall  = !cs_n && !sclk && sclk_q;
    assign cs_up = cs_n && !cs_q;

    // Edge history of the serial clock and the select line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Receive shifter, bit and byte counters, frame-end report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            byte_stb  <= 1'b0;
            end_stb   <= 1'b0;
            end_whole <= 1'b0;
            end_bytes <= '0;
        end else begin
            byte_stb <= 1'b0;
            end_stb  <= 1'b0;
            if (cs_n) begin
                if (cs_up) begin
                    end_stb   <= 1'b1;
                    end_whole <= (bit_cnt == 3'd0) && (byte_cnt != '0);
                    end_bytes <= byte_cnt;
                end
                bit_cnt  <= '0;
                byte_cnt <= '0;
            end else if (rise) begin
                rx_sr   <= {rx_sr[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    rx_byte  <= {rx_sr, mosi};
                    if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

    // Transmit shifter: loads a new response byte at each byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            miso  <= 1'b0;
            tx_sr <= '0;
        end else if (fall) begin
            if (bit_cnt == 3'd0) begin
                miso  <= resp_byte[7];
                tx_sr <= resp_byte[6:0];
            end else begin
                miso  <= tx_sr[6];
                tx_sr <= {tx_sr[5:0], 1'b0};
            end
        end
    end

    AST_MISO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso); // R1
endmodule

// File: rtl/sfc_busy_timer.sv
// Countdown that models the busy period of a program or erase.
// Assumes load_val is at least 1; pause freezes the remaining count.
module sfc_busy_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load_val,
    input  logic          pause,
    output logic          busy,
    output logic          done
);
    logic          run;
    logic [CW-1:0] cnt;

    assign busy = run && !pause;
    assign done = busy && (cnt == CW'(1));

    // Load on start, count down while not paused, stop at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= load_val;
        end else if (done) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0)); // R5
endmodule

// File: rtl/sfc_cmd_ctrl.sv
// Opcode screening, write-enable latch, suspend and power-down state,
// and the response byte multiplexer.
// Assumes byte_cnt counts completed bytes of the current frame and is
// already updated when byte_stb is seen.
module sfc_cmd_ctrl
    import sfc_pkg::*;
#(
    parameter int          CNT_W        = 5,
    parameter int          CW           = 13,
    parameter int          PROG_CYCLES  = 2000,
    parameter int          ERASE_CYCLES = 6000,
    parameter logic [23:0] JEDEC_ID     = 24'h9D7A16,
    parameter logic [63:0] UNIQUE_ID    = 64'h0123_4567_89AB_CDEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_stb,
    input  logic [7:0]       rx_byte,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             end_stb,
    input  logic             end_whole,
    input  logic [CNT_W-1:0] end_bytes,
    input  logic             busy,
    input  logic             done,
    output logic [7:0]       resp_byte,
    output logic             go_start,
    output logic [CW-1:0]    load_val,
    output logic             susp
);
    logic [7:0]  op;
    logic        ok, wel, pd, acc, exec, go_susp, go_resume;
    logic [23:0] rd_ptr;
    job_e        job, new_job;
    int          bc, eb;

    assign bc   = int'(byte_cnt);
    assign eb   = int'(end_bytes);
    assign exec = end_stb && end_whole && ok;

    // Admission of a new opcode in the current mode.
    always_comb begin
        if (pd)        acc = (rx_byte == OP_REL);
        else if (busy) acc = (rx_byte == OP_RDSR) || (rx_byte == OP_SUSP);
        else if (susp) acc = rx_byte inside {OP_RDSR, OP_WREN, OP_WRDI, OP_RESM,
                                             OP_FREAD, OP_JID, OP_UID};
        else           acc = rx_byte inside {OP_RDSR, OP_WREN, OP_WRDI, OP_WRSR,
                                             OP_PROG, OP_FREAD, OP_SE, OP_BE, OP_CE,
                                             OP_PDN, OP_REL, OP_JID, OP_UID};
    end

    // Frame-end decisions for commands that start a busy period.
    always_comb begin
        go_start = 1'b0;
        new_job  = JOB_WRITE;
        if (exec && wel) begin
            unique case (op)
                OP_WRSR:      go_start = (eb >= 2);
                OP_PROG:      go_start = (eb >= 5);
                OP_SE, OP_BE: begin go_start = (eb == 4); new_job = JOB_ERASE; end
                OP_CE:        begin go_start = (eb == 1); new_job = JOB_ERASE; end
                default:      go_start = 1'b0;
            endcase
        end
        load_val  = (new_job == JOB_ERASE) ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
        go_susp   = exec && (op == OP_SUSP) && (eb == 1) && busy && (job == JOB_ERASE);
        go_resume = exec && (op == OP_RESM) && (eb == 1) && susp;
    end

    // Opcode capture, admission flag and fast-read address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op     <= '0;
            ok     <= 1'b0;
            rd_ptr <= '0;
        end else if (end_stb) begin
            ok <= 1'b0;
        end else if (byte_stb) begin
            if (bc == 1) begin
                op <= rx_byte;
                ok <= acc;
            end else if (op == OP_FREAD && bc >= 2 && bc <= 4) begin
                rd_ptr <= {rd_ptr[15:0], rx_byte};
            end else if (op == OP_FREAD && bc >= 6) begin
                rd_ptr <= rd_ptr + 24'd1;
            end
        end
    end

    // Latch, suspend, power-down and job-kind state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            susp <= 1'b0;
            pd   <= 1'b0;
            job  <= JOB_WRITE;
        end else begin
            if (done) wel <= 1'b0;
            else if (exec && op == OP_WREN && eb == 1) wel <= 1'b1;
            else if (exec && op == OP_WRDI && eb == 1) wel <= 1'b0;
            if (go_susp) susp <= 1'b1;
            else if (go_resume) susp <= 1'b0;
            if (exec && op == OP_PDN && eb == 1) pd <= 1'b1;
            else if (exec && op == OP_REL) pd <= 1'b0;
            if (go_start) job <= new_job;
        end
    end

    // Response byte for the next byte slot of the frame.
    always_comb begin
        resp_byte = 8'h00;
        if (ok) begin
            unique case (op)
                OP_RDSR:  resp_byte = {susp, 5'b0, wel, busy};
                OP_JID:   if (bc >= 1 && bc <= 3)
                              resp_byte = 8'(JEDEC_ID >> (8 * (3 - bc)));
                OP_UID:   if (bc >= 5 && bc <= 12)
                              resp_byte = 8'(UNIQUE_ID >> (8 * (12 - bc)));
                OP_FREAD: if (bc >= 5) resp_byte = rd_ptr[7:0];
                default:  resp_byte = 8'h00;
            endcase
        end
    end

    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel); // R5
    AST_SUSPEND_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> !busy); // R7
    AST_POWERDOWN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> !busy); // R9
    AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_start || go_resume)); // R8
endmodule

// File: rtl/sflash_cmd_ctrl.sv
// Top of the serial flash command and status controller: serial port,
// command control and busy countdown. Assumes a single clock domain.
module sflash_cmd_ctrl #(
    parameter int          CNT_W        = 5,
    parameter int          PROG_CYCLES  = 2000,
    parameter int          ERASE_CYCLES = 6000,
    parameter logic [23:0] JEDEC_ID     = 24'h9D7A16,
    parameter logic [63:0] UNIQUE_ID    = 64'h0123_4567_89AB_CDEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int LONGEST = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW      = $clog2(LONGEST + 1);

    logic             byte_stb, end_stb, end_whole, busy, done, go_start, susp;
    logic [7:0]       rx_byte, resp_byte;
    logic [CNT_W-1:0] byte_cnt, end_bytes;
    logic [CW-1:0]    load_val;

    sfc_spi_port #(.CNT_W(CNT_W)) u_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .resp_byte(resp_byte), .miso(miso), .byte_stb(byte_stb), .rx_byte(rx_byte),
        .byte_cnt(byte_cnt), .end_stb(end_stb), .end_whole(end_whole),
        .end_bytes(end_bytes)
    );

    sfc_cmd_ctrl #(
        .CNT_W(CNT_W), .CW(CW), .PROG_CYCLES(PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .JEDEC_ID(JEDEC_ID), .UNIQUE_ID(UNIQUE_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .rx_byte(rx_byte),
        .byte_cnt(byte_cnt), .end_stb(end_stb), .end_whole(end_whole),
        .end_bytes(end_bytes), .busy(busy), .done(done), .resp_byte(resp_byte),
        .go_start(go_start), .load_val(load_val), .susp(susp)
    );

    sfc_busy_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(go_start), .load_val(load_val),
        .pause(susp), .busy(busy), .done(done)
    );
endmodule

// File: tb/tb_sflash_cmd_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_sflash_cmd_ctrl;
    localparam int          HALF  = 4;
    localparam int          PROG  = 2000;
    localparam int          ERASE = 6000;
    localparam logic [23:0] JID   = 24'h9D7A16;
    localparam logic [63:0] UID   = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    int   checks = 0, errors = 0;
    bit   finished = 1'b0;

    sflash_cmd_ctrl #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE),
                      .JEDEC_ID(JID), .UNIQUE_ID(UID)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    always #5 clk = ~clk;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0; gap(HALF);
    endtask

    task automatic desel();
        gap(HALF); cs_n = 1'b1; gap(3 * HALF);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            gap(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            gap(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] opc);
        logic [7:0] d;
        sel(); xfer(opc, d); desel();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R12 miso after reset", {7'b0, miso}, 8'h00);
        rd_status(s);
        chk("R12 status after reset", s, 8'h00);
    endtask

    task automatic t_ids();
        logic [7:0] d;
        sel(); xfer(8'h9F, d);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, d);
            chk("R11 R1 JEDEC byte", d, JID[8*(2-k) +: 8]);
        end
        desel();
        sel(); xfer(8'h4B, d);
        for (int k = 0; k < 4; k++) xfer(8'h00, d);
        for (int k = 0; k < 8; k++) begin
            xfer(8'h00, d);
            chk("R11 unique id byte", d, UID[8*(7-k) +: 8]);
        end
        desel();
    endtask

    task automatic t_fast_read();
        logic [7:0] d;
        sel(); xfer(8'h0B, d); xfer(8'h12, d); xfer(8'h34, d); xfer(8'h5A, d); xfer(8'h00, d);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, d);
            chk("R10 fast read data", d, 8'(8'h5A + k));
        end
        desel();
    endtask

    task automatic t_latch();
        logic [7:0] s, d;
        cmd1(8'h06); rd_status(s);
        chk("R3 latch set", s, 8'h02);
        sel(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, d); desel();
        chk("R2 repeated status byte", d, 8'h02);
        cmd1(8'h04); rd_status(s);
        chk("R3 latch cleared", s, 8'h00);
        sel(); bits(8'h06, 4, d); desel();
        rd_status(s);
        chk("R3 partial byte ignored", s, 8'h00);
    endtask

    task automatic t_gating();
        logic [7:0] s, d;
        sel(); xfer(8'h20, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'h00, d); desel();
        rd_status(s);
        chk("R4 erase without latch ignored", s, 8'h00);
        cmd1(8'h06);
        sel(); xfer(8'h20, d); xfer(8'h00, d); xfer(8'h10, d); desel();
        rd_status(s);
        chk("R4 short erase ignored", s, 8'h02);
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d);
        xfer(8'hA5, d); bits(8'h3C, 3, d); desel();
        rd_status(s);
        chk("R4 program cut mid-byte ignored", s, 8'h02);
        cmd1(8'h04);
    endtask

    task automatic t_program_busy();
        logic [7:0] s, d;
        int n;
        cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h01, d); xfer(8'h00, d); xfer(8'hC3, d); desel();
        rd_status(s);
        chk("R5 program busy with latch", s, 8'h03);
        sel(); xfer(8'h0B, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h5A, d); xfer(8'h00, d);
        xfer(8'h00, d);
        chk("R6 fast read silent while busy", d, 8'h00);
        desel();
        cmd1(8'h04); rd_status(s);
        chk("R6 latch clear ignored while busy", s, 8'h03);
        cmd1(8'h75); rd_status(s);
        chk("R7 suspend of program ignored", s, 8'h03);
        cmd1(8'h7A); rd_status(s);
        chk("R8 resume without suspend ignored", s, 8'h03);
        sel(); xfer(8'h05, d); xfer(8'h00, s);
        chk("R2 live status first byte", s, 8'h03);
        n = 0;
        while (s != 8'h00 && n < 80) begin
            xfer(8'h00, s);
            n++;
        end
        desel();
        chk("R2 R5 busy and latch drop in one frame", s, 8'h00);
    endtask

    task automatic t_erase_suspend();
        logic [7:0] s, d;
        cmd1(8'h06);
        sel(); xfer(8'h20, d); xfer(8'h00, d); xfer(8'h20, d); xfer(8'h00, d); desel();
        rd_status(s);
        chk("R4 sector erase busy", s, 8'h03);
        cmd1(8'h75); rd_status(s);
        chk("R7 suspended status", s, 8'h82);
        gap(ERASE + 100); rd_status(s);
        chk("R7 count frozen while suspended", s, 8'h82);
        sel(); xfer(8'hD8, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d); desel();
        rd_status(s);
        chk("R7 erase rejected while suspended", s, 8'h82);
        cmd1(8'h7A); rd_status(s);
        chk("R8 resume sets busy", s, 8'h03);
        gap(ERASE + 100); rd_status(s);
        chk("R8 R5 erase finishes after resume", s, 8'h00);
    endtask

    task automatic t_power_down();
        logic [7:0] s, d;
        cmd1(8'h06); cmd1(8'hB9);
        rd_status(s);
        chk("R9 status ignored in power-down", s, 8'h00);
        sel(); xfer(8'h9F, d); xfer(8'h00, d); desel();
        chk("R9 id ignored in power-down", d, 8'h00);
        cmd1(8'h04); cmd1(8'hAB);
        rd_status(s);
        chk("R9 release keeps latch", s, 8'h02);
        cmd1(8'hC7); rd_status(s);
        chk("R4 chip erase busy", s, 8'h03);
        cmd1(8'hB9); rd_status(s);
        chk("R9 power-down ignored while busy", s, 8'h03);
        gap(ERASE + 100); rd_status(s);
        chk("R5 chip erase done", s, 8'h00);
    endtask

    initial begin
        gap(5);
        rst_n = 1'b1;
        gap(2);
        t_reset();
        t_ids();
        t_fast_read();
        t_latch();
        t_gating();
        t_program_busy();
        t_erase_suspend();
        t_power_down();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule